// File: doc/BRIEF.md
# Exclusive Bus Lock Controller

This block guards internal memory against outside traffic while the local CPU runs a critical sequence. The CPU side raises a lock request and later an unlock request. Two kinds of external traffic can be kept out while the lock is held: a bus-hold handshake, where an external master asks for the bus and receives a hold acknowledge, and a slave access, where an external master selects the internal memory and waits for a data-complete response. A one-bit mode setting decides which of the two is shut out.

A lock request is not granted while a transfer of the kind being guarded is still in progress. The request waits until that transfer has been released. Only then does the block enter the locked state, and it gives a one-cycle ready pulse so the CPU side can resume. While the lock is held, the guarded acknowledge is withheld. The other kind of traffic is still served normally. A mode write made while the lock is held is kept aside and takes effect when the lock is released.

Top module: `excl_lock_ctrl`

## Requirements
- R1: After reset the mode bit is 0 and `cfg_rdata` is all zero. `locked` and `lock_ready` are low, and `hold_ack_n` and `data_done_n` are high. The mode bit is read back at bit 0 of `cfg_rdata`, and every other bit reads 0 whatever value was written.
- R2: When the hold channel is not blocked, `hold_ack_n` goes low one cycle after the edge that samples `hold_req_n` low. It goes high one cycle after the edge that samples `hold_req_n` high.
- R3: With mode 0 and the lock held, `hold_ack_n` stays high even while `hold_req_n` is low. A request still pending is acknowledged one cycle after `locked` falls.
- R4: With mode 0, a lock request made while the hold is acknowledged waits. `locked` rises two cycles after the edge that samples `hold_req_n` high.
- R5: When the slave channel is not blocked, `data_done_n` goes low one cycle after `chip_sel_n` is sampled low and high one cycle after it is sampled high. With mode 1 and the lock held, `data_done_n` stays high, and a waiting access completes one cycle after `locked` falls.
- R6: With mode 1, a lock request made while `data_done_n` is low waits. `locked` rises two cycles after the edge that samples `chip_sel_n` high.
- R7: While locked, the channel that mode does not select keeps working. With mode 1 a hold request is still acknowledged, and with mode 0 a slave access is still completed.
- R8: An accepted lock request raises `locked` on the next cycle. `unlock_req` while locked clears it on the next cycle. `lock_req` while locked has no effect. `unlock_req` while unlocked or while a lock is waiting has no effect.
- R9: `lock_ready` is high for exactly one cycle: the first cycle in which `locked` is high.
- R10: A mode write made while unlocked shows in `cfg_rdata` one cycle later. A write made while locked, or in the cycle a lock is accepted, is held back. It takes effect in the same cycle `locked` falls, and a write made in the unlock cycle itself wins.
- R11: If `lock_req` and a new request on the guarded channel are sampled at the same edge while idle, the lock is granted. The external request is then held off until unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| lock_req | input | 1 | One-cycle pulse from the CPU side asking for the lock |
| unlock_req | input | 1 | One-cycle pulse from the CPU side releasing the lock |
| lock_ready | output | 1 | One-cycle pulse when the lock is granted |
| locked | output | 1 | High while the lock is held |
| cfg_we | input | 1 | Write enable for the mode register |
| cfg_wdata | input | REG_W | Write data; bit 0 is the mode (0 guards bus hold, 1 guards slave access) |
| cfg_rdata | output | REG_W | Effective mode at bit 0, all other bits zero |
| hold_req_n | input | 1 | Active-low bus-hold request from an external master |
| hold_ack_n | output | 1 | Active-low, registered hold acknowledge |
| chip_sel_n | input | 1 | Active-low slave select of the internal memory |
| data_done_n | output | 1 | Active-low, registered data-complete response |

## Verification
Two things can land on the same clock edge: a lock grant and a new request on the guarded channel. Another pair is an unlock and a mode write. The bench drives `lock_req` in the same cycle `chip_sel_n` falls, and in the cycle the guarded acknowledge is released. It also writes the mode in the unlock cycle. It then checks that the lock wins, that the deferred request is served one cycle after `locked` falls, and that the write made in the unlock cycle is the one that takes effect. A long random phase then lets these collisions happen freely, and every cycle is compared with a behavioural model.

// File: rtl/xl_pkg.sv
package xl_pkg;
  // Channel indices; the mode value equals the index of the guarded channel.
  localparam int unsigned CH_HOLD = 0;
  localparam int unsigned CH_SLV  = 1;
  localparam int unsigned NUM_CH  = 2;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_WAIT = 2'd1,
    LK_HELD = 2'd2
  } lock_state_e;
endpackage

// File: rtl/xl_rst_sync.sv
module xl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xl_grant_chan.sv
module xl_grant_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic block,
  output logic gnt
);
  logic gnt_q, gnt_d;

  // A grant already given is kept; a new one needs the channel unblocked.
  always_comb begin
    gnt_d = req & (gnt_q | ~block);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/xl_lock_fsm.sv
module xl_lock_fsm
  import xl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_req,
  input  logic unlock_req,
  input  logic busy,
  output logic accept,
  output logic release_now,
  output logic locked,
  output logic ready
);
  lock_state_e state_q, state_d;
  logic        ready_q;

  always_comb begin
    state_d     = state_q;
    accept      = 1'b0;
    release_now = 1'b0;
    unique case (state_q)
      LK_IDLE: begin
        if (lock_req) begin
          if (busy) begin
            state_d = LK_WAIT;
          end else begin
            state_d = LK_HELD;
            accept  = 1'b1;
          end
        end
      end
      LK_WAIT: begin
        if (!busy) begin
          state_d = LK_HELD;
          accept  = 1'b1;
        end
      end
      LK_HELD: begin
        if (unlock_req) begin
          state_d     = LK_IDLE;
          release_now = 1'b1;
        end
      end
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= accept;
    end
  end

  assign locked = (state_q == LK_HELD);
  assign ready  = ready_q;
endmodule

// File: rtl/xl_mode_reg.sv
module xl_mode_reg #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned MODE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             hold_off,
  input  logic             release_now,
  output logic             mode,
  output logic [REG_W-1:0] rdata
);
  logic mode_q, mode_d;
  logic pend_v_q, pend_v_d;
  logic pend_m_q, pend_m_d;
  logic wbit;

  assign wbit = wdata[MODE_BIT];

  always_comb begin
    mode_d   = mode_q;
    pend_v_d = pend_v_q;
    pend_m_d = pend_m_q;
    if (release_now) begin
      if (we)            mode_d = wbit;
      else if (pend_v_q) mode_d = pend_m_q;
      pend_v_d = 1'b0;
    end else if (hold_off) begin
      if (we) begin
        pend_v_d = 1'b1;
        pend_m_d = wbit;
      end
    end else if (we) begin
      mode_d = wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      pend_v_q <= 1'b0;
      pend_m_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pend_v_q <= pend_v_d;
      pend_m_q <= pend_m_d;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[MODE_BIT] = mode_q;
  end

  assign mode = mode_q;
endmodule

// File: rtl/excl_lock_ctrl.sv
module excl_lock_ctrl
  import xl_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned MODE_BIT    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_req,
  input  logic             unlock_req,
  output logic             lock_ready,
  output logic             locked,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             hold_req_n,
  output logic             hold_ack_n,
  input  logic             chip_sel_n,
  output logic             data_done_n
);
  logic              rst_int_n;
  logic              mode;
  logic              accept;
  logic              release_now;
  logic              busy;
  logic [NUM_CH-1:0] ch_req;
  logic [NUM_CH-1:0] ch_block;
  logic [NUM_CH-1:0] ch_gnt;

  xl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign ch_req[CH_HOLD] = ~hold_req_n;
  assign ch_req[CH_SLV]  = ~chip_sel_n;

  // Only the guarded channel counts as an in-flight transfer for the lock.
  assign busy = ch_gnt[mode];

  xl_lock_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lock_req    (lock_req),
    .unlock_req  (unlock_req),
    .busy        (busy),
    .accept      (accept),
    .release_now (release_now),
    .locked      (locked),
    .ready       (lock_ready)
  );

  xl_mode_reg #(.REG_W(REG_W), .MODE_BIT(MODE_BIT)) u_mode (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .we          (cfg_we),
    .wdata       (cfg_wdata),
    .hold_off    (locked | accept),
    .release_now (release_now),
    .mode        (mode),
    .rdata       (cfg_rdata)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    // The grant edge itself also blocks, so the lock wins a same-cycle race.
    assign ch_block[k] = (mode == k[0]) & (locked | accept);

    xl_grant_chan u_chan (
      .clk   (clk),
      .rst_n (rst_int_n),
      .req   (ch_req[k]),
      .block (ch_block[k]),
      .gnt   (ch_gnt[k])
    );
  end

  assign hold_ack_n  = ~ch_gnt[CH_HOLD];
  assign data_done_n = ~ch_gnt[CH_SLV];
endmodule

// File: rtl/xl_checker.sv
module xl_checker #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned MODE_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_req_n,
  input logic             chip_sel_n,
  input logic             hold_ack_n,
  input logic             data_done_n,
  input logic             locked,
  input logic             lock_ready,
  input logic [REG_W-1:0] cfg_rdata
);
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ready |=> !lock_ready); // R9

  AST_READY_ON_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> lock_ready); // R9

  AST_HOLD_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cfg_rdata[MODE_BIT]) |-> hold_ack_n); // R3

  AST_SLAVE_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_rdata[MODE_BIT]) |-> data_done_n); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(cfg_rdata)); // R10

  AST_HOLD_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> $past(!hold_req_n)); // R2

  AST_DONE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !data_done_n |-> $past(!chip_sel_n)); // R5

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_rdata) <= 1); // R1
endmodule

bind excl_lock_ctrl xl_checker #(.REG_W(REG_W), .MODE_BIT(MODE_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_req_n  (hold_req_n),
  .chip_sel_n  (chip_sel_n),
  .hold_ack_n  (hold_ack_n),
  .data_done_n (data_done_n),
  .locked      (locked),
  .lock_ready  (lock_ready),
  .cfg_rdata   (cfg_rdata)
);

// File: tb/excl_lock_ctrl_bench.sv
`timescale 1ns/100ps
module excl_lock_ctrl_bench;
  localparam int REG_W = 8;

  logic             clk;
  logic             rst_n;
  logic             lock_req, unlock_req, cfg_we;
  logic [REG_W-1:0] cfg_wdata;
  logic             hold_req_n, chip_sel_n;
  logic             lock_ready, locked, hold_ack_n, data_done_n;
  logic [REG_W-1:0] cfg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  excl_lock_ctrl u_excl_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .unlock_req(unlock_req),
    .lock_ready(lock_ready), .locked(locked), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
    .chip_sel_n(chip_sel_n), .data_done_n(data_done_n)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Behavioural reference model
  bit m_mode, m_pv, m_pm, m_locked, m_wait, m_ready, m_hg, m_cg;
  bit busy, want, acc, blk_h, blk_c, n_mode, n_pv, n_pm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pv = 0; m_pm = 0; m_locked = 0; m_wait = 0;
      m_ready = 0; m_hg = 0; m_cg = 0;
    end else begin
      busy  = m_mode ? m_cg : m_hg;
      want  = m_wait || (!m_locked && lock_req);
      acc   = want && !busy;
      blk_h = !m_mode && (m_locked || acc);
      blk_c = m_mode && (m_locked || acc);
      n_mode = m_mode; n_pv = m_pv; n_pm = m_pm;
      if (m_locked && unlock_req) begin
        if (cfg_we) n_mode = cfg_wdata[0];
        else if (m_pv) n_mode = m_pm;
        n_pv = 0;
      end else if (m_locked || acc) begin
        if (cfg_we) begin n_pv = 1; n_pm = cfg_wdata[0]; end
      end else if (cfg_we) begin
        n_mode = cfg_wdata[0];
      end
      m_hg     = !hold_req_n && (m_hg || !blk_h);
      m_cg     = !chip_sel_n && (m_cg || !blk_c);
      m_locked = m_locked ? !unlock_req : acc;
      m_wait   = want && busy;
      m_ready  = acc;
      m_mode = n_mode; m_pv = n_pv; m_pm = n_pm;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Compare with the model on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R8 locked vs model",      locked,      m_locked);
      chk("R9 lock_ready vs model",  lock_ready,  m_ready);
      chk("R2 hold_ack_n vs model",  hold_ack_n,  !m_hg);
      chk("R5 data_done_n vs model", data_done_n, !m_cg);
      chk("R1 cfg_rdata vs model",   cfg_rdata,   {7'd0, m_mode});
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_lock();
    lock_req = 1; step(); lock_req = 0;
  endtask

  task automatic pulse_unlock();
    unlock_req = 1; step(); unlock_req = 0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0;
  endtask

  // Watchdog
  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lock_req = 0; unlock_req = 0; cfg_we = 0; cfg_wdata = '0;
    hold_req_n = 1; chip_sel_n = 1;
    step(3);
    rst_n = 1;
    step(4);
    // R1 reset state
    chk("R1 locked after reset", locked, 0);
    chk("R1 ready after reset", lock_ready, 0);
    chk("R1 hold_ack_n after reset", hold_ack_n, 1);
    chk("R1 data_done_n after reset", data_done_n, 1);
    chk("R1 rdata after reset", cfg_rdata, 0);

    // R2 hold handshake
    hold_req_n = 0; step();
    chk("R2 ack low", hold_ack_n, 0);
    hold_req_n = 1; step();
    chk("R2 ack high", hold_ack_n, 1);

    // R4 lock stalled behind granted hold (mode 0)
    hold_req_n = 0; step();
    pulse_lock();
    chk("R4 waiting, not locked", locked, 0);
    unlock_req = 1; step(); unlock_req = 0;   // R8 unlock while waiting: no effect
    chk("R8 unlock while waiting", locked, 0);
    hold_req_n = 1; step();
    chk("R4 ack released", hold_ack_n, 1);
    chk("R4 still waiting", locked, 0);
    step();
    chk("R4 locked after release", locked, 1);
    chk("R9 ready pulse", lock_ready, 1);
    step();
    chk("R9 ready one cycle", lock_ready, 0);

    // R3 hold withheld while locked (mode 0); R7 slave still served
    hold_req_n = 0; chip_sel_n = 0; step(3);
    chk("R3 ack withheld", hold_ack_n, 1);
    chk("R7 slave served in mode 0", data_done_n, 0);
    chip_sel_n = 1;
    pulse_unlock();
    chk("R8 unlocked", locked, 0);
    chk("R3 ack still high at unlock", hold_ack_n, 1);
    step();
    chk("R3 ack after unlock", hold_ack_n, 0);
    hold_req_n = 1; step(2);

    // R10 mode register
    wr_mode(8'hFF);
    chk("R1 only mode bit reads back", cfg_rdata, 8'h01);
    wr_mode(8'h00);
    chk("R10 immediate write", cfg_rdata, 0);
    pulse_lock();
    chk("R8 locked", locked, 1);
    wr_mode(8'h01);
    chk("R10 write deferred", cfg_rdata, 0);
    lock_req = 1; step(); lock_req = 0;
    chk("R8 lock while locked no ready", lock_ready, 0);
    chk("R8 still locked", locked, 1);
    pulse_unlock();
    chk("R10 pending applied on unlock", cfg_rdata, 1);
    // write in lock-accept cycle is deferred; write at unlock wins
    lock_req = 1; cfg_we = 1; cfg_wdata = 8'h00; step(); lock_req = 0; cfg_we = 0;
    chk("R10 write at accept deferred", cfg_rdata, 1);
    unlock_req = 1; cfg_we = 1; cfg_wdata = 8'h01; step(); unlock_req = 0; cfg_we = 0;
    chk("R10 unlock-cycle write wins", cfg_rdata, 1);
    chk("R8 unlocked again", locked, 0);

    // R5 / R7 in mode 1
    chip_sel_n = 0; step();
    chk("R5 done low", data_done_n, 0);
    chip_sel_n = 1; step();
    chk("R5 done high", data_done_n, 1);
    pulse_lock();
    hold_req_n = 0; step();
    chk("R7 hold granted in mode 1", hold_ack_n, 0);
    chip_sel_n = 0; step(2);
    chk("R5 done withheld", data_done_n, 1);
    pulse_unlock();
    chk("R5 done still high at unlock", data_done_n, 1);
    step();
    chk("R5 done after unlock", data_done_n, 0);
    chip_sel_n = 1; hold_req_n = 1; step(2);

    // R6 lock stalled behind slave access
    chip_sel_n = 0; step();
    pulse_lock();
    chk("R6 waiting", locked, 0);
    chip_sel_n = 1; step();
    chk("R6 still waiting", locked, 0);
    step();
    chk("R6 locked", locked, 1);
    pulse_unlock(); step();

    // R11 same-cycle race: lock wins
    chip_sel_n = 0; lock_req = 1; step(); lock_req = 0;
    chk("R11 lock wins", locked, 1);
    chk("R11 access deferred", data_done_n, 1);
    step();
    chk("R11 still deferred", data_done_n, 1);
    pulse_unlock(); step();
    chk("R11 served after unlock", data_done_n, 0);
    chip_sel_n = 1; step(2);

    // Random phase, checked against the model each cycle
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 64;
      lock_req   = (r < 5);
      unlock_req = (r >= 5 && r < 9);
      if ($urandom % 6 == 0) hold_req_n = ~hold_req_n;
      if ($urandom % 6 == 0) chip_sel_n = ~chip_sel_n;
      cfg_we    = ($urandom % 20 == 0);
      cfg_wdata = 8'($urandom);
      step();
    end
    lock_req = 0; unlock_req = 0; cfg_we = 0;
    step(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule